// File: doc/BRIEF.md
# Multi-Level Page Table Walker

This block turns a virtual address into a final page entry by walking a four-level table in memory. A walk is started with a virtual address, a table root address and a translation-enable flag. It returns one 64-bit leaf entry, or zero when the walk fails. With translation on, the walker reads one entry per level through a request/response read port. It follows table descriptors downward and stops at the first leaf, at an entry that is neither leaf nor descriptor, at an entry address outside the memory, or after the last level.

A leaf found above the bottom level covers a large page. So that a 4 KiB translation cache can hold it, the walker ORs the virtual page bits below that level into the physical page field. The result then looks like a bottom-level entry. With translation off, no memory is read: an address inside the memory gets an identity entry with every permission bit set, and any other address gets zero.

Top module: `ptw_top`

## Requirements
- R1: Out of reset, `busy_o`, `done_o` and `rd_req_o` are low and `result_o` is zero.
- R2: With `xlate_en_i` low, a start with `va_i` below `MEM_BYTES` gives the result `((va_i >> 12) << 12) | 0x3F0 | 0x2`. That is bit 1 set, permission bits 9:4 set and page number `va_i >> 12`. A start with `va_i` at or above `MEM_BYTES` gives zero. Neither case issues a memory read.
- R3: At level k (k = 0..3, root first), the walker reads the entry at `base + 8*idx`. Here idx is `(va >> (12 + 9*(3-k))) & 0x1FF`, and the base for level 0 is `ptbase_i`. There is exactly one read per level visited, and every read address is 8-byte aligned.
- R4: `rd_req_o` stays high with a stable `rd_addr_o` until `rd_gnt_i` is seen. The entry is then taken from `rd_data_i` in the cycle `rd_vld_i` is high.
- R5: An entry with bit 1 set ends the walk as a leaf. With s = 9*(3-k), the result is `entry | ((va >> 12) & ((1 << s) - 1)) << 12`. Bit 1 has priority over bit 0.
- R6: An entry with bits 1 and 0 both clear ends the walk with result zero, whatever its other bits are.
- R7: An entry with bit 0 set and bit 1 clear is a table descriptor. The next level uses the entry with bits 11:0 cleared as its base.
- R8: If an entry address is at or above `MEM_BYTES`, the walk ends with result zero and no read is issued for that address. An address of `MEM_BYTES - 8` is still read.
- R9: If the level-3 entry is also a table descriptor, the walk ends with result zero after four reads.
- R10: Each walk ends with `done_o` high for exactly one cycle, with the result on `result_o`. `busy_o` is high from the cycle after the start until that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a walk; sampled only while idle |
| va_i | input | 64 | Virtual address to translate |
| ptbase_i | input | 64 | Root table byte address |
| xlate_en_i | input | 1 | Translation on; low selects identity mapping |
| busy_o | output | 1 | Walk in progress |
| rd_req_o | output | 1 | Entry read request |
| rd_addr_o | output | 64 | Entry read byte address |
| rd_gnt_i | input | 1 | Read request accepted |
| rd_vld_i | input | 1 | Read data valid |
| rd_data_i | input | 64 | Entry read data |
| done_o | output | 1 | One-cycle walk completion |
| result_o | output | 64 | Leaf entry, or zero on failure |

## Verification
The bench builds the walker with `MEM_BYTES` set to 32 KiB instead of the large default. That lets the bench memory back the whole address space, so both sides of the bound are reachable. A root at `0x7000` with index 511 lands exactly on the last legal entry. A descriptor pointing at `0x8000`, or a root placed there, lands on the first illegal one. The small bound also lets the identity mapping be tried just below and exactly at the memory size. Random grant and response delays exercise the held request of the read port.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_DONE
  } ptw_state_e;

  localparam int unsigned TBL_BIT  = 0;
  localparam int unsigned LEAF_BIT = 1;
  localparam int unsigned PERM_LO  = 4;
  localparam int unsigned PERM_W   = 6;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int unsigned ADDR_W    = 64,
  parameter int unsigned LEVELS    = 4,
  parameter int unsigned IDX_BITS  = 9,
  parameter int unsigned PG_SHIFT  = 12,
  parameter int unsigned PTE_BYTES = 8,
  parameter logic [63:0] MEM_BYTES = 64'h8000_0000,
  localparam int unsigned LVL_W    = $clog2(LEVELS),
  localparam int unsigned OFF_BITS = $clog2(PTE_BYTES)
) (
  input  logic [ADDR_W-1:0] va_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [LVL_W-1:0]  lvl_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              oob_o
);
  logic [IDX_BITS-1:0] idx_lvl [LEVELS];

  for (genvar g = 0; g < LEVELS; g++) begin : g_idx
    assign idx_lvl[g] = va_i[PG_SHIFT + (LEVELS-1-g)*IDX_BITS +: IDX_BITS];
  end

  assign addr_o = base_i + (ADDR_W'(idx_lvl[lvl_i]) << OFF_BITS);
  assign oob_o  = addr_o >= ADDR_W'(MEM_BYTES);
endmodule

// File: rtl/ptw_leaf_fmt.sv
module ptw_leaf_fmt
  import ptw_pkg::*;
#(
  parameter int unsigned DATA_W    = 64,
  parameter int unsigned LEVELS    = 4,
  parameter int unsigned IDX_BITS  = 9,
  parameter int unsigned PG_SHIFT  = 12,
  parameter logic [63:0] MEM_BYTES = 64'h8000_0000,
  localparam int unsigned LVL_W    = $clog2(LEVELS)
) (
  input  logic [DATA_W-1:0] va_i,
  input  logic [LVL_W-1:0]  lvl_i,
  input  logic [DATA_W-1:0] pte_i,
  output logic [DATA_W-1:0] leaf_o,
  output logic [DATA_W-1:0] ident_o
);
  localparam logic [DATA_W-1:0] PERM_MASK = DATA_W'({PERM_W{1'b1}}) << PERM_LO;
  localparam logic [DATA_W-1:0] LEAF_MASK = DATA_W'(1) << LEAF_BIT;

  logic [DATA_W-1:0] vpn;
  logic [DATA_W-1:0] mask_lvl [LEVELS];

  assign vpn = va_i >> PG_SHIFT;

  // low vpn bits not consumed by the levels above this one
  for (genvar g = 0; g < LEVELS; g++) begin : g_mask
    assign mask_lvl[g] = (DATA_W'(1) << ((LEVELS-1-g)*IDX_BITS)) - DATA_W'(1);
  end

  assign leaf_o  = pte_i | ((vpn & mask_lvl[lvl_i]) << PG_SHIFT);
  assign ident_o = (va_i < DATA_W'(MEM_BYTES))
                 ? ((vpn << PG_SHIFT) | PERM_MASK | LEAF_MASK)
                 : '0;
endmodule

// File: rtl/ptw_top.sv
module ptw_top
  import ptw_pkg::*;
#(
  parameter int unsigned ADDR_W    = 64,
  parameter int unsigned DATA_W    = 64,
  parameter int unsigned LEVELS    = 4,
  parameter int unsigned IDX_BITS  = 9,
  parameter int unsigned PG_SHIFT  = 12,
  parameter int unsigned PTE_BYTES = 8,
  parameter logic [63:0] MEM_BYTES = 64'h8000_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] va_i,
  input  logic [ADDR_W-1:0] ptbase_i,
  input  logic              xlate_en_i,
  output logic              busy_o,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_gnt_i,
  input  logic              rd_vld_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              done_o,
  output logic [DATA_W-1:0] result_o
);
  localparam int unsigned LVL_W = $clog2(LEVELS);
  localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS-1);

  ptw_state_e        state_q;
  logic [LVL_W-1:0]  lvl_q;
  logic [ADDR_W-1:0] va_q, base_q;
  logic [DATA_W-1:0] result_q;

  logic [ADDR_W-1:0] ent_addr;
  logic              ent_oob;
  logic [DATA_W-1:0] va_sel, leaf_val, ident_val;

  assign va_sel = (state_q == ST_IDLE) ? DATA_W'(va_i) : DATA_W'(va_q);

  ptw_addr_gen #(
    .ADDR_W   (ADDR_W),
    .LEVELS   (LEVELS),
    .IDX_BITS (IDX_BITS),
    .PG_SHIFT (PG_SHIFT),
    .PTE_BYTES(PTE_BYTES),
    .MEM_BYTES(MEM_BYTES)
  ) u_addr (
    .va_i  (va_q),
    .base_i(base_q),
    .lvl_i (lvl_q),
    .addr_o(ent_addr),
    .oob_o (ent_oob)
  );

  ptw_leaf_fmt #(
    .DATA_W   (DATA_W),
    .LEVELS   (LEVELS),
    .IDX_BITS (IDX_BITS),
    .PG_SHIFT (PG_SHIFT),
    .MEM_BYTES(MEM_BYTES)
  ) u_leaf (
    .va_i   (va_sel),
    .lvl_i  (lvl_q),
    .pte_i  (rd_data_i),
    .leaf_o (leaf_val),
    .ident_o(ident_val)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      lvl_q    <= '0;
      va_q     <= '0;
      base_q   <= '0;
      result_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          va_q   <= va_i;
          base_q <= ptbase_i;
          lvl_q  <= '0;
          if (xlate_en_i) begin
            state_q <= ST_REQ;
          end else begin
            result_q <= ident_val;
            state_q  <= ST_DONE;
          end
        end
        ST_REQ: begin
          if (ent_oob) begin
            result_q <= '0;
            state_q  <= ST_DONE;
          end else if (rd_gnt_i) begin
            state_q <= ST_WAIT;
          end
        end
        ST_WAIT: if (rd_vld_i) begin
          if (rd_data_i[LEAF_BIT]) begin
            result_q <= leaf_val;
            state_q  <= ST_DONE;
          end else if (!rd_data_i[TBL_BIT]) begin
            result_q <= '0;
            state_q  <= ST_DONE;
          end else if (lvl_q == LAST_LVL) begin
            result_q <= '0;
            state_q  <= ST_DONE;
          end else begin
            base_q  <= ADDR_W'((rd_data_i >> PG_SHIFT) << PG_SHIFT);
            lvl_q   <= lvl_q + 1'b1;
            state_q <= ST_REQ;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o    = state_q != ST_IDLE;
  assign rd_req_o  = (state_q == ST_REQ) && !ent_oob;
  assign rd_addr_o = ent_addr;
  assign done_o    = state_q == ST_DONE;
  assign result_o  = result_q;
endmodule

// File: rtl/ptw_chk.sv
module ptw_chk #(
  parameter int unsigned ADDR_W    = 64,
  parameter int unsigned DATA_W    = 64,
  parameter int unsigned PTE_BYTES = 8,
  parameter logic [63:0] MEM_BYTES = 64'h8000_0000,
  localparam int unsigned OFF_BITS = $clog2(PTE_BYTES)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              rd_req_o,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic              rd_gnt_i,
  input logic              done_o,
  input logic [DATA_W-1:0] result_o
);
  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_req_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !rd_gnt_i |=> rd_req_o && $stable(rd_addr_o));

  assert_req_busy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> busy_o && !done_o);

  assert_req_in_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> rd_addr_o < ADDR_W'(MEM_BYTES));

  assert_req_align_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> rd_addr_o[OFF_BITS-1:0] == '0);

  assert_nonzero_is_leaf_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && (result_o != '0) |-> result_o[1]);
endmodule

bind ptw_top ptw_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .PTE_BYTES(PTE_BYTES),
  .MEM_BYTES(MEM_BYTES)
) u_ptw_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .busy_o   (busy_o),
  .rd_req_o (rd_req_o),
  .rd_addr_o(rd_addr_o),
  .rd_gnt_i (rd_gnt_i),
  .done_o   (done_o),
  .result_o (result_o)
);

// File: tb/ptw_top_tb_top.sv
`timescale 1ns/1ps
module ptw_top_tb_top;
  localparam logic [63:0] MEM = 64'h8000;
  localparam int unsigned WORDS = 4096;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [63:0] va_i = '0;
  logic [63:0] ptbase_i = '0;
  logic        xlate_en_i = 1'b0;
  logic        busy_o, rd_req_o, done_o;
  logic [63:0] rd_addr_o, result_o;
  logic        rd_gnt_i = 1'b0;
  logic        rd_vld_i = 1'b0;
  logic [63:0] rd_data_i = '0;

  logic [63:0] mem [WORDS];
  logic [63:0] exp_q [$];
  int          rd_q [$];
  string       tag_q [$];
  int          checks = 0;
  int          errors = 0;
  int          nreads = 0;
  bit          finished = 1'b0;

  always #4 clk_i = ~clk_i;

  ptw_top #(.MEM_BYTES(MEM)) dut_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .va_i      (va_i),
    .ptbase_i  (ptbase_i),
    .xlate_en_i(xlate_en_i),
    .busy_o    (busy_o),
    .rd_req_o  (rd_req_o),
    .rd_addr_o (rd_addr_o),
    .rd_gnt_i  (rd_gnt_i),
    .rd_vld_i  (rd_vld_i),
    .rd_data_i (rd_data_i),
    .done_o    (done_o),
    .result_o  (result_o)
  );

  function automatic logic [63:0] mkva(input int i0, i1, i2, i3, input int off);
    return (64'(i0) << 39) | (64'(i1) << 30) | (64'(i2) << 21) | (64'(i3) << 12) | 64'(off);
  endfunction

  // model built from the requirements
  function automatic logic [63:0] ref_walk(input logic [63:0] va, input logic [63:0] base,
                                           input bit en, output int nrd);
    logic [63:0] a, e;
    int sh;
    nrd = 0;
    if (!en) return (va < MEM) ? (((va >> 12) << 12) | 64'h3F2) : 64'h0;
    for (int k = 0; k < 4; k++) begin
      sh = 9 * (3 - k);
      a  = base + (((va >> (12 + sh)) & 64'h1FF) << 3);
      if (a >= MEM) return 64'h0;
      nrd++;
      e = mem[a[14:3]];
      if (e[1]) return e | (((va >> 12) & ((64'd1 << sh) - 64'd1)) << 12);
      if (!e[0]) return 64'h0;
      base = (e >> 12) << 12;
    end
    return 64'h0;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [63:0] addr, input logic [63:0] val);
    mem[addr[14:3]] = val;
  endtask

  // driver: push expectation, start walk, wait until idle again
  task automatic run(input string tag, input logic [63:0] va, input logic [63:0] base,
                     input bit en, input logic [63:0] exp, input int exp_rd);
    exp_q.push_back(exp);
    rd_q.push_back(exp_rd);
    tag_q.push_back(tag);
    @(negedge clk_i);
    nreads     = 0;
    va_i       = va;
    ptbase_i   = base;
    xlate_en_i = en;
    start_i    = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    while (busy_o) @(negedge clk_i);
  endtask

  task automatic run_ref(input string tag, input logic [63:0] va, input logic [63:0] base,
                         input bit en);
    int n;
    logic [63:0] e;
    e = ref_walk(va, base, en, n);
    run(tag, va, base, en, e, n);
  endtask

  // monitor: pop and compare on every completion
  initial begin
    forever begin
      @(negedge clk_i);
      if (done_o) begin
        if (exp_q.size() == 0) begin
          check("R10 unexpected done", 64'(done_o), 64'h0);
        end else begin
          check({tag_q[0], " result"}, result_o, exp_q[0]);
          check({tag_q[0], " reads R3"}, 64'(nreads), 64'(rd_q[0]));
          void'(exp_q.pop_front());
          void'(rd_q.pop_front());
          void'(tag_q.pop_front());
        end
      end
    end
  end

  // memory responder with random grant and response delays
  initial begin
    bit          pend = 1'b0;
    int          dly = 0;
    logic [63:0] pdata = '0;
    bit          held = 1'b0;
    logic [63:0] held_addr = '0;
    forever begin
      @(negedge clk_i);
      if (held) begin
        check("R4 request held", {rd_req_o, rd_addr_o == held_addr}, 2'b11);
      end
      rd_gnt_i = 1'b0;
      rd_vld_i = 1'b0;
      held     = 1'b0;
      if (pend) begin
        if (dly == 0) begin
          rd_vld_i  = 1'b1;
          rd_data_i = pdata;
          pend      = 1'b0;
        end else begin
          dly--;
        end
      end else if (rd_req_o) begin
        if ($urandom_range(0, 2) != 0) begin
          rd_gnt_i = 1'b1;
          pdata    = mem[rd_addr_o[14:3]];
          dly      = $urandom_range(0, 2);
          pend     = 1'b1;
          nreads++;
        end else begin
          held      = 1'b1;
          held_addr = rd_addr_o;
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < WORDS; i++) mem[i] = '0;
    // table chain: root 0x1000 -> 0x2000 -> 0x3000 -> 0x4000
    put(64'h1000 + 5*8,     64'h2001);
    put(64'h2000 + 7*8,     64'h3001);
    put(64'h3000 + 9*8,     64'h4001);
    put(64'h4000 + 3*8,     64'h0012_33F2);
    put(64'h1000 + 1*8,     64'h0000_8000_0000_00F2);
    put(64'h3000 + 2*8,     64'h0000_0000_4000_0006);
    put(64'h2000 + 3*8,     64'h0000_1000_0000_0203);
    put(64'h3000 + 4*8,     64'hFFFF_0000_0000_03F0);
    put(64'h4000 + 6*8,     64'h5001);
    put(64'h3000 + 10*8,    64'h8001);
    put(64'h7000 + 511*8,   64'h0000_0000_0066_6012);

    repeat (3) @(negedge clk_i);
    check("R1 busy in reset", 64'(busy_o), 64'h0);
    check("R1 done in reset", 64'(done_o), 64'h0);
    check("R1 req in reset", 64'(rd_req_o), 64'h0);
    check("R1 result in reset", result_o, 64'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 idle after reset", {busy_o, done_o, rd_req_o}, 3'b000);

    run("R2 identity low", 64'h5123, 64'h1000, 1'b0, 64'h53F2, 0);
    run("R2 identity top", 64'h7FFF, 64'h1000, 1'b0, 64'h73F2, 0);
    run("R2 identity at bound", 64'h8000, 64'h1000, 1'b0, 64'h0, 0);
    run("R3 R7 four-level leaf", mkva(5, 7, 9, 3, 12'hABC), 64'h1000, 1'b1, 64'h0012_33F2, 4);
    run_ref("R5 level0 leaf merge", mkva(1, 9'h1AB, 9'h0CD, 9'h012, 12'h345), 64'h1000, 1'b1);
    run("R5 level0 leaf literal", mkva(1, 9'h1AB, 9'h0CD, 9'h012, 0), 64'h1000, 1'b1,
        64'h0000_8000_0000_00F2 | (((64'h1AB << 18) | (64'h0CD << 9) | 64'h012) << 12), 1);
    run_ref("R5 level2 leaf merge", mkva(5, 7, 2, 9'h1FF, 0), 64'h1000, 1'b1);
    run_ref("R5 leaf bit priority", mkva(5, 3, 9'h155, 9'h0AA, 0), 64'h1000, 1'b1);
    run("R6 empty entry", mkva(5, 8, 0, 0, 0), 64'h1000, 1'b1, 64'h0, 2);
    run("R6 no type bits", mkva(5, 7, 4, 1, 0), 64'h1000, 1'b1, 64'h0, 3);
    run("R9 levels exhausted", mkva(5, 7, 9, 6, 0), 64'h1000, 1'b1, 64'h0, 4);
    run("R8 descriptor out of range", mkva(5, 7, 10, 0, 0), 64'h1000, 1'b1, 64'h0, 3);
    run("R8 root out of range", mkva(0, 0, 0, 0, 0), 64'h8000, 1'b1, 64'h0, 0);
    run("R8 last legal entry", mkva(9'h1FF, 0, 0, 0, 0), 64'h7000, 1'b1,
        64'h0000_0000_0066_6012 | (64'h0 << 12), 1);

    for (int i = 0; i < 24; i++) begin
      run_ref("R5 R6 R7 random walk",
              mkva($urandom_range(0, 6), $urandom_range(0, 9), $urandom_range(0, 11),
                   $urandom_range(0, 7), $urandom_range(0, 4095)),
              64'h1000, 1'b1);
      run_ref("R2 random identity", 64'($urandom_range(0, 16'hFFFF)), 64'h1000, 1'b0);
    end

    repeat (4) @(negedge clk_i);
    check("R10 queue drained", 64'(exp_q.size()), 64'h0);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule